// File: doc/BRIEF.md
# Banked Partition Bandwidth-Portion Permission Store

This block holds, for every partition ID, a bitmap that says which bandwidth portions the partition may use. A set bit n lets the partition allocate bandwidth in portion n; a clear bit forbids it. Two banks exist, one for secure and one for non-secure partitions. They share no storage, and the bus request's security flag picks the bank.

Software programs a bitmap indirectly. It first writes the partition-select register of a bank. It then reads or writes the selected partition's bitmap through a window of consecutive 32-bit words. The bitmap width is a parameter. Bits at or above it are not stored.

A combinational lookup port takes a security flag, a partition ID and a portion index, and reports whether that partition may use that portion. The bandwidth regulator uses it on every decision.

Top module: `pbm_store`

## Requirements
- R1: `req_ready` is always high. Every accepted request (`req_valid` high at a rising edge) raises `rsp_valid` for exactly the next cycle, and `rsp_rdata` carries the read data in that cycle. Writes and idle cycles return 0 on `rsp_rdata`.
- R2: Each bank has its own partition-select register at byte offset 0x100. It holds the low 16 bits of the written data and reads back as those 16 bits, zero-extended. It resets to 0.
- R3: A window access at byte offset 0x2000 + 4k reaches bits [32k+31:32k] of the bitmap of the partition named by the same bank's select register. Reads return those bits and writes replace them.
- R4: `lk_allow` is the stored bit `lk_portion` of the bitmap of partition `lk_pid` in the bank chosen by `lk_secure` (1 = secure).
- R5: A write through one bank never changes any bitmap or select value of the other bank.
- R6: Bitmap bits at or above `BM_WIDTH` read as 0 in the last window word, and writes to them are ignored.
- R7: Window words k with 32k ≥ `BM_WIDTH` (up to k = 127) read 0, and writes to them change nothing. Every other unmapped offset also reads 0.
- R8: When the select value is `NUM_PART` or more, window reads return 0 and window writes are dropped.
- R9: After reset every bitmap bit below `BM_WIDTH` is 1 in both banks.
- R10: A window write accepted at an edge changes `lk_allow` right after that edge and not before it.
- R11: With `PRESENT` = 0, window reads return 0, window writes have no effect, and `lk_allow` is 1 for every portion below `BM_WIDTH`.
- R12: `lk_allow` is 0 whenever `lk_portion` ≥ `BM_WIDTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Frame select: 1 = secure bank, 0 = non-secure bank |
| req_addr | input | 16 | Byte offset within the configuration frame |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| lk_secure | input | 1 | Lookup bank select |
| lk_pid | input | PID_W | Lookup partition ID |
| lk_portion | input | IDX_W | Lookup bandwidth portion index |
| lk_allow | output | 1 | 1 = partition may use the portion |

## Verification
A corrupted bitmap bit shows up on `lk_allow` as soon as the lookup port names that partition and portion. Because the port is combinational, this needs no bus traffic. The same bit also shows in `rsp_rdata` one cycle after a window read. A select register that holds the wrong value, or a bank mix-up, makes a window read return the wrong partition's word or zero in the response cycle of that read. A write aimed at the wrong word or bits is visible on the lookup port in the cycle right after the write edge. The bench compares the port at that cycle.

// File: rtl/pbm_pkg.sv
// pbm_pkg: constants and types shared by the partition bitmap store.
// Assumes a 64 KiB configuration frame addressed by a 16-bit byte offset.
package pbm_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 16;
    localparam int WORD_W    = 7;            // up to 128 window words
    localparam int SEL_W     = 16;           // partition-select field width
    localparam logic [6:0]  WIN_PAGE = 7'h10;  // addr[15:9] of 0x2000..0x21FF
    localparam logic [13:0] SEL_WORD = 14'h40; // addr[15:2] of 0x100

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SEL  = 2'd1,
        ACC_WIN  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [WORD_W-1:0]  word;
    } acc_dec_t;

    // Number of 32-bit words needed to cover a bitmap of the given width.
    function automatic int words_for(input int bits);
        return (bits + DATA_W - 1) / DATA_W;
    endfunction
endpackage

// File: rtl/pbm_decode.sv
// pbm_decode: classifies a frame byte offset as partition-select register,
// bitmap window word, or unmapped. Pure combinational; byte lanes within a
// word are ignored (accesses are assumed word aligned).
module pbm_decode
    import pbm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output acc_dec_t          dec
);
    // Decode the offset into an access kind and window word index.
    always_comb begin
        dec.kind = ACC_NONE;
        dec.word = addr[8:2];
        if (addr[15:9] == WIN_PAGE) begin
            dec.kind = ACC_WIN;
        end else if (addr[15:2] == SEL_WORD) begin
            dec.kind = ACC_SEL;
        end
    end
endmodule

// File: rtl/pbm_bank.sv
// pbm_bank: one security bank. It holds the partition-select register and
// one BM_WIDTH-bit permission bitmap per partition. It exposes the selected
// partition's bitmap as 32-bit words and answers combinational lookups.
// Assumes the caller qualifies sel_we and win_we with an accepted request.
// With PRESENT = 0 the bitmaps are never written and the outputs are forced,
// so the storage is left for synthesis to remove.
module pbm_bank
    import pbm_pkg::*;
#(
    parameter int NUM_PART = 8,
    parameter int BM_WIDTH = 70,
    parameter bit PRESENT  = 1'b1,
    parameter int PID_W    = 3,
    parameter int IDX_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic              win_we,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DATA_W-1:0] win_rdata,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [IDX_W-1:0]  lk_portion,
    output logic              lk_allow
);
    localparam int NUM_WORDS = words_for(BM_WIDTH);

    logic [BM_WIDTH-1:0]              bmap [NUM_PART];
    logic [BM_WIDTH-1:0]              cur_map;
    logic [BM_WIDTH-1:0]              wmask;
    logic [BM_WIDTH-1:0]              wwide;
    logic [NUM_WORDS-1:0][DATA_W-1:0] rd_words;
    logic [DATA_W-1:0]                sel_word;
    logic [PID_W-1:0]                 sel_idx;
    logic                             sel_ok;
    logic                             word_ok;
    logic                             pid_ok;
    logic                             portion_ok;

    // Range qualifiers for the selected partition, word and lookup inputs.
    always_comb begin
        sel_ok     = (32'(sel_q) < NUM_PART);
        word_ok    = (32'(word) < NUM_WORDS);
        pid_ok     = (32'(lk_pid) < NUM_PART);
        portion_ok = (32'(lk_portion) < BM_WIDTH);
        sel_idx    = sel_q[PID_W-1:0];
    end

    // Spread the write word over the bitmap and build the per-bit word mask.
    for (genvar b = 0; b < BM_WIDTH; b++) begin : g_wbit
        assign wmask[b] = (word == WORD_W'(b / DATA_W));
        assign wwide[b] = wdata[b % DATA_W];
    end

    // Partition-select register, reset to partition 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= wdata[SEL_W-1:0];
        end
    end

    // Bitmap storage: all ones at reset, masked word update on a valid write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PART; p++) begin
                bmap[p] <= '1;
            end
        end else if (PRESENT && win_we && sel_ok && word_ok) begin
            bmap[sel_idx] <= (bmap[sel_idx] & ~wmask) | (wwide & wmask);
        end
    end

    // Bitmap of the currently selected partition (don't-care when out of range).
    always_comb begin
        cur_map = '0;
        for (int p = 0; p < NUM_PART; p++) begin
            if (32'(sel_q) == p) begin
                cur_map = bmap[p];
            end
        end
    end

    // Cut the selected bitmap into 32-bit words, zero above BM_WIDTH.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_rword
        for (genvar b = 0; b < DATA_W; b++) begin : g_rbit
            if (w * DATA_W + b < BM_WIDTH) begin : g_live
                assign rd_words[w][b] = cur_map[w * DATA_W + b];
            end else begin : g_pad
                assign rd_words[w][b] = 1'b0;
            end
        end
    end

    // Pick the addressed window word.
    always_comb begin
        sel_word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (32'(word) == w) begin
                sel_word = rd_words[w];
            end
        end
    end

    // Window read data, zero when absent or out of range.
    always_comb begin
        win_rdata = (PRESENT && sel_ok && word_ok) ? sel_word : '0;
    end

    // Lookup: stored permission bit, or all-allowed when the feature is absent.
    always_comb begin
        if (!PRESENT) begin
            lk_allow = portion_ok;
        end else begin
            lk_allow = pid_ok && portion_ok && bmap[lk_pid][lk_portion];
        end
    end
endmodule

// File: rtl/pbm_store.sv
// pbm_store: top of the banked partition bitmap store. It decodes requests
// from a valid/ready register bus, steers writes to the bank named by
// req_secure, and registers a one-cycle response. The lookup output is
// taken from the bank named by lk_secure. Index 1 is the secure bank and
// index 0 the non-secure bank.
module pbm_store
    import pbm_pkg::*;
#(
    parameter int NUM_PART = 8,
    parameter int BM_WIDTH = 70,
    parameter bit PRESENT  = 1'b1,
    localparam int PID_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
    localparam int IDX_W   = (BM_WIDTH > 1) ? $clog2(BM_WIDTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              lk_secure,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [IDX_W-1:0]  lk_portion,
    output logic              lk_allow
);
    acc_dec_t          dec;
    logic              accept;
    logic [SEL_W-1:0]  bank_sel  [2];
    logic [DATA_W-1:0] bank_rd   [2];
    logic              bank_allow[2];
    logic [DATA_W-1:0] rd_next;

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;

    pbm_decode u_decode (
        .addr (req_addr),
        .dec  (dec)
    );

    // One bank per security state; writes reach only the addressed bank.
    for (genvar s = 0; s < 2; s++) begin : g_bank
        logic sel_we_s;
        logic win_we_s;
        assign sel_we_s = accept && req_write && (req_secure == 1'(s))
                          && (dec.kind == ACC_SEL);
        assign win_we_s = accept && req_write && (req_secure == 1'(s))
                          && (dec.kind == ACC_WIN);

        pbm_bank #(
            .NUM_PART (NUM_PART),
            .BM_WIDTH (BM_WIDTH),
            .PRESENT  (PRESENT),
            .PID_W    (PID_W),
            .IDX_W    (IDX_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_we     (sel_we_s),
            .win_we     (win_we_s),
            .word       (dec.word),
            .wdata      (req_wdata),
            .sel_q      (bank_sel[s]),
            .win_rdata  (bank_rd[s]),
            .lk_pid     (lk_pid),
            .lk_portion (lk_portion),
            .lk_allow   (bank_allow[s])
        );
    end

    // Read data selection for the addressed bank and register.
    always_comb begin
        rd_next = '0;
        if (!req_write) begin
            unique case (dec.kind)
                ACC_SEL: rd_next = DATA_W'(bank_sel[req_secure]);
                ACC_WIN: rd_next = bank_rd[req_secure];
                default: rd_next = '0;
            endcase
        end
    end

    // Registered single-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_rdata <= accept ? rd_next : '0;
        end
    end

    // Lookup result from the bank named by the lookup security flag.
    assign lk_allow = bank_allow[lk_secure];
endmodule

// File: rtl/pbm_store_chk.sv
// pbm_store_chk: port-level properties of pbm_store, bound to every instance.
module pbm_store_chk
    import pbm_pkg::*;
#(
    parameter int NUM_PART = 8,
    parameter int BM_WIDTH = 70,
    parameter bit PRESENT  = 1'b1,
    parameter int PID_W    = 3,
    parameter int IDX_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              lk_secure,
    input logic [PID_W-1:0]  lk_pid,
    input logic [IDX_W-1:0]  lk_portion,
    input logic              lk_allow
);
    localparam int NUM_WORDS = words_for(BM_WIDTH);
    localparam int TAIL      = BM_WIDTH - DATA_W * (NUM_WORDS - 1);
    localparam logic [DATA_W-1:0] PAD_MASK =
        (TAIL >= DATA_W) ? '0 : ~((DATA_W'(1) << TAIL) - DATA_W'(1));

    logic win_rd;
    logic rd_dead;
    logic rd_last;
    logic wr_acc;

    // Window-read classification of the current request.
    always_comb begin
        win_rd  = req_valid && req_ready && !req_write && (req_addr[15:9] == WIN_PAGE);
        rd_dead = win_rd && (!PRESENT || (32'(req_addr[8:2]) >= NUM_WORDS));
        rd_last = win_rd && (32'(req_addr[8:2]) == NUM_WORDS - 1);
        wr_acc  = req_valid && req_ready && req_write;
    end

    AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready);                                                   // R1
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);                      // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);                    // R1
    AST_DEAD_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dead |=> (rsp_rdata == '0));                               // R7
    AST_TAIL_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> ((rsp_rdata & PAD_MASK) == '0));                  // R6
    AST_PORTION_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(lk_portion) >= BM_WIDTH) |-> !lk_allow);                 // R12
    AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wr_acc) && $stable(lk_secure) && $stable(lk_pid)
         && $stable(lk_portion)) |-> $stable(lk_allow));              // R10
endmodule

bind pbm_store pbm_store_chk #(
    .NUM_PART (NUM_PART),
    .BM_WIDTH (BM_WIDTH),
    .PRESENT  (PRESENT),
    .PID_W    (PID_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .lk_secure  (lk_secure),
    .lk_pid     (lk_pid),
    .lk_portion (lk_portion),
    .lk_allow   (lk_allow)
);

// File: tb/tb_pbm_store.sv
// tb_pbm_store: directed bench. One task per scenario; each checks its own
// results at the falling edge. Two instances share the request bus and the
// lookup inputs: dut (feature present) and dut_abs (feature absent).
module tb_pbm_store;
    localparam int NUM_PART = 8;
    localparam int BM_WIDTH = 70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        lk_secure = 1'b0;
    logic [2:0]  lk_pid = '0;
    logic [6:0]  lk_portion = '0;

    logic        req_ready, rsp_valid, lk_allow;
    logic [31:0] rsp_rdata;
    logic        req_ready_abs, rsp_valid_abs, lk_allow_abs;
    logic [31:0] rsp_rdata_abs;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic last_rv;

    always #2 clk = ~clk;

    pbm_store #(.NUM_PART(NUM_PART), .BM_WIDTH(BM_WIDTH), .PRESENT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .lk_secure(lk_secure), .lk_pid(lk_pid), .lk_portion(lk_portion),
        .lk_allow(lk_allow)
    );

    pbm_store #(.NUM_PART(NUM_PART), .BM_WIDTH(BM_WIDTH), .PRESENT(1'b0)) dut_abs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_abs),
        .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid_abs), .rsp_rdata(rsp_rdata_abs),
        .lk_secure(lk_secure), .lk_pid(lk_pid), .lk_portion(lk_portion),
        .lk_allow(lk_allow_abs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sec, input logic [15:0] addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_secure = sec;
        req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        last_rv = rsp_valid;
    endtask

    task automatic bus_rd(input logic sec, input logic [15:0] addr,
                          output logic [31:0] data, output logic [31:0] data_abs);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_secure = sec; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        last_rv = rsp_valid;
        data = rsp_rdata;
        data_abs = rsp_rdata_abs;
    endtask

    task automatic look(input logic sec, input logic [2:0] pid, input logic [6:0] portion,
                        output logic allow, output logic allow_abs);
        lk_secure = sec; lk_pid = pid; lk_portion = portion;
        #1;
        allow = lk_allow;
        allow_abs = lk_allow_abs;
    endtask

    task automatic t_reset_state;
        logic [31:0] d, da;
        logic a, aa;
        bus_rd(1'b1, 16'h0100, d, da); chk("R2 select resets to 0", d, 32'h0);
        bus_rd(1'b1, 16'h2000, d, da); chk("R9 word0 all ones", d, 32'hFFFF_FFFF);
        bus_rd(1'b0, 16'h2004, d, da); chk("R9 ns word1 all ones", d, 32'hFFFF_FFFF);
        bus_rd(1'b1, 16'h2008, d, da); chk("R6 R9 word2 tail", d, 32'h0000_003F);
        look(1'b0, 3'd5, 7'd69, a, aa); chk("R9 lookup last portion", 32'(a), 32'h1);
        look(1'b1, 3'd7, 7'd0, a, aa);  chk("R4 R9 lookup portion 0", 32'(a), 32'h1);
        look(1'b1, 3'd2, 7'd70, a, aa); chk("R12 portion 70", 32'(a), 32'h0);
        look(1'b0, 3'd2, 7'd127, a, aa); chk("R12 portion 127", 32'(a), 32'h0);
    endtask

    task automatic t_bus_protocol;
        logic [31:0] d, da;
        chk("R1 ready high", 32'(req_ready), 32'h1);
        bus_rd(1'b0, 16'h0100, d, da);
        chk("R1 response after read", 32'(last_rv), 32'h1);
        bus_wr(1'b0, 16'h0040, 32'h1234_5678);
        chk("R1 response after write", 32'(last_rv), 32'h1);
        chk("R1 write returns zero data", rsp_rdata, 32'h0);
        @(negedge clk);
        chk("R1 response lasts one cycle", 32'(rsp_valid), 32'h0);
    endtask

    task automatic t_write_lookup;
        logic [31:0] d, da;
        logic a, aa;
        bus_wr(1'b1, 16'h0100, 32'hABCD_0003);
        bus_rd(1'b1, 16'h0100, d, da); chk("R2 select keeps low 16 bits", d, 32'h0000_0003);
        look(1'b1, 3'd3, 7'd36, a, aa);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_secure = 1'b1;
        req_addr = 16'h2004; req_wdata = 32'hA5A5_0F0F;
        #1; chk("R10 unchanged before edge", 32'(lk_allow), 32'h1);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R10 cleared after edge", 32'(lk_allow), 32'h0);
        look(1'b1, 3'd3, 7'd32, a, aa); chk("R4 portion 32 set", 32'(a), 32'h1);
        look(1'b1, 3'd3, 7'd63, a, aa); chk("R4 portion 63 set", 32'(a), 32'h1);
        look(1'b1, 3'd3, 7'd62, a, aa); chk("R4 portion 62 clear", 32'(a), 32'h0);
        bus_rd(1'b1, 16'h2004, d, da); chk("R3 word1 readback", d, 32'hA5A5_0F0F);
        bus_rd(1'b1, 16'h2000, d, da); chk("R3 word0 untouched", d, 32'hFFFF_FFFF);
        look(1'b1, 3'd2, 7'd36, a, aa); chk("R3 other partition untouched", 32'(a), 32'h1);
    endtask

    task automatic t_bank_split;
        logic [31:0] d, da;
        logic a, aa;
        look(1'b0, 3'd3, 7'd36, a, aa); chk("R5 ns partition 3 untouched", 32'(a), 32'h1);
        bus_rd(1'b0, 16'h0100, d, da); chk("R5 ns select still 0", d, 32'h0);
        bus_wr(1'b0, 16'h0100, 32'h0000_0003);
        bus_rd(1'b0, 16'h2004, d, da); chk("R5 ns word1 all ones", d, 32'hFFFF_FFFF);
        bus_wr(1'b0, 16'h2000, 32'h0000_0000);
        look(1'b0, 3'd3, 7'd5, a, aa); chk("R5 ns write took effect", 32'(a), 32'h0);
        look(1'b1, 3'd3, 7'd5, a, aa); chk("R5 secure word0 kept", 32'(a), 32'h1);
    endtask

    task automatic t_tail_bits;
        logic [31:0] d, da;
        logic a, aa;
        bus_wr(1'b1, 16'h2008, 32'hFFFF_FF00);
        bus_rd(1'b1, 16'h2008, d, da); chk("R6 tail bits ignored", d, 32'h0000_0000);
        look(1'b1, 3'd3, 7'd64, a, aa); chk("R6 portion 64 cleared", 32'(a), 32'h0);
        bus_wr(1'b1, 16'h2008, 32'hFFFF_FFC1);
        bus_rd(1'b1, 16'h2008, d, da); chk("R6 only live bits stored", d, 32'h0000_0001);
        look(1'b1, 3'd3, 7'd64, a, aa); chk("R6 portion 64 set", 32'(a), 32'h1);
        look(1'b1, 3'd3, 7'd69, a, aa); chk("R6 portion 69 clear", 32'(a), 32'h0);
    endtask

    task automatic t_beyond_words;
        logic [31:0] d, da;
        bus_wr(1'b1, 16'h200C, 32'h0000_0000);
        bus_rd(1'b1, 16'h200C, d, da); chk("R7 word3 reads zero", d, 32'h0);
        bus_wr(1'b1, 16'h21FC, 32'h0000_0000);
        bus_rd(1'b1, 16'h21FC, d, da); chk("R7 word127 reads zero", d, 32'h0);
        bus_rd(1'b1, 16'h2000, d, da); chk("R7 word0 unaffected", d, 32'hFFFF_FFFF);
        bus_rd(1'b1, 16'h2004, d, da); chk("R7 word1 unaffected", d, 32'hA5A5_0F0F);
        bus_rd(1'b1, 16'h2200, d, da); chk("R7 past window reads zero", d, 32'h0);
        bus_rd(1'b1, 16'h0040, d, da); chk("R7 unmapped offset reads zero", d, 32'h0);
    endtask

    task automatic t_bad_select;
        logic [31:0] d, da;
        logic a, aa;
        bus_wr(1'b1, 16'h0100, 32'h0000_0009);
        bus_rd(1'b1, 16'h0100, d, da); chk("R2 select holds 9", d, 32'h0000_0009);
        bus_rd(1'b1, 16'h2000, d, da); chk("R8 out-of-range select reads zero", d, 32'h0);
        bus_wr(1'b1, 16'h2000, 32'h0000_0000);
        look(1'b1, 3'd1, 7'd0, a, aa); chk("R8 write not aliased to pid 1", 32'(a), 32'h1);
        bus_wr(1'b1, 16'h0100, 32'h0000_0003);
        bus_rd(1'b1, 16'h2000, d, da); chk("R8 write dropped", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_absent;
        logic [31:0] d, da;
        logic a, aa;
        bus_rd(1'b1, 16'h2000, d, da); chk("R11 absent window reads zero", da, 32'h0);
        bus_rd(1'b1, 16'h0100, d, da); chk("R11 absent select readback", da, 32'h0000_0003);
        look(1'b1, 3'd3, 7'd36, a, aa); chk("R11 absent lookup allowed", 32'(aa), 32'h1);
        look(1'b0, 3'd3, 7'd5, a, aa);  chk("R11 absent ns lookup allowed", 32'(aa), 32'h1);
        look(1'b1, 3'd3, 7'd70, a, aa); chk("R11 R12 absent portion 70", 32'(aa), 32'h0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    // Main sequence.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_bus_protocol();
        t_write_lookup();
        t_bank_split();
        t_tail_bits();
        t_beyond_words();
        t_bad_select();
        t_absent();
        done = 1'b1;
        finish_run();
    end
endmodule